// File: doc/BRIEF.md
# Segmented Tap-Loadable Shift Register

The block is a 64-stage serial shift register built from four 16-stage segments. Each segment ends in a tap. In shift mode (write enable low) data enters at stage 1 and moves one stage toward stage 64 on each rising clock edge. The four taps drive out the contents of stages 16, 32, 48 and 64, so the register can be read at four points along its length.

When write enable is high, the taps after stages 16, 32 and 48 stop driving and act as inputs. On each rising edge the first stage of the second, third and fourth segments takes its value from the tap before it, not from the preceding stage. Stage 1 still takes the serial input. All four segments therefore fill side by side, and a full 64-bit word loads in 16 clocks instead of 64.

Each tap is modelled as a three-state pin through three separate signals: an input, an output and an output enable. The stage-64 tap is output-only. A synchronous active-low reset clears every stage. A dual arrangement is made by placing two instances side by side.

Top module: `tapshift_reg`

## Requirements
- R1: If `rst_n` is 0 at a rising clock edge, all 64 stages become 0 and every bit of `tap_out` reads 0 after that edge.
- R2: If `rst_n` is 1 and `wr_en` is 0 at a rising edge, stage 1 takes `din` and every stage n from 2 to 64 takes the old value of stage n-1.
- R3: `tap_out` bit k (k = 0..3) always shows the current content of stage 16·(k+1). Bit 0 is stage 16 and bit 3 is stage 64.
- R4: If `rst_n` is 1 and `wr_en` is 1 at a rising edge, stage 1 takes `din`, stage 17 takes `tap_in[0]`, stage 33 takes `tap_in[1]` and stage 49 takes `tap_in[2]`. Every other stage, stage 64 included, takes the old value of the stage before it.
- R5: After 16 consecutive write clocks, the bit presented to segment k (serial input for k = 0, `tap_in[k-1]` otherwise) on write clock j (j = 0..15) sits in stage 16·k + 16 − j. A 64-bit word is therefore loaded in 16 clocks.
- R6: `tap_oe` depends only on the current `wr_en`, with no clock delay. It is all zeros when `wr_en` is 1 (taps released) and all ones when `wr_en` is 0 (taps driven).
- R7: While `wr_en` is 0, `tap_in` has no effect on any stage.
- R8: Reset takes priority over write mode. A rising edge with `rst_n` at 0 clears the register whatever the values on `wr_en`, `din` and `tap_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages update on the rising edge |
| rst_n | input | 1 | Synchronous active-low clear |
| din | input | 1 | Serial input into stage 1 |
| wr_en | input | 1 | 1 = parallel segment load with taps as inputs, 0 = serial shift |
| tap_in | input | NUM_SEGS-1 (3) | Tap pin values feeding stages 17, 33, 49 in write mode |
| tap_out | output | NUM_SEGS (4) | Contents of stages 16, 32, 48, 64 |
| tap_oe | output | NUM_SEGS (4) | Per-tap drive enable, 1 = driving |

## Verification
Stage contents show up on `tap_out` right after the rising edge that loads them, with no further register delay. The bench therefore samples `tap_out` one nanosecond after each rising edge and compares it with a reference array that it updates at the same edge. `tap_oe` is combinational from `wr_en`, so it is checked one nanosecond after inputs change on the falling edge, before the next rising edge. The 16-clock load is checked at the end of its sequence, where a long-delay result is due: the word is shifted out serially and each bit is read at stage 64 on the cycle in which the shift count says it arrives.

// File: rtl/tsr_pkg.sv
// Package: shared sizing defaults and helpers for the segmented tap register.
// Assumes segments are equal length and that the register depth is their product.
package tsr_pkg;
    localparam int unsigned DEF_SEG_LEN  = 16;
    localparam int unsigned DEF_NUM_SEGS = 4;

    // Zero-based index of the first stage of a segment.
    function automatic int unsigned seg_head(input int unsigned seg, input int unsigned seg_len);
        return seg * seg_len;
    endfunction

    // Zero-based index of the last stage of a segment (its tap point).
    function automatic int unsigned seg_tail(input int unsigned seg, input int unsigned seg_len);
        return seg * seg_len + seg_len - 1;
    endfunction
endpackage

// File: rtl/tsr_segment.sv
// Module: one segment of the register, a plain serial chain of flip-flops.
// bits[0] is the head stage and takes 'entry'. bits[LEN-1] is the tail stage (the tap).
// Assumes LEN >= 2. The clear is synchronous and active low.
module tsr_segment #(
    parameter int unsigned LEN = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           entry,
    output logic [LEN-1:0] bits
);
    // Advance the chain by one stage per rising edge, or clear it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits <= '0;
        end else begin
            bits <= {bits[LEN-2:0], entry};
        end
    end
endmodule

// File: rtl/tsr_entry_mux.sv
// Module: picks the value entering the head of each segment.
// Segment 0 always takes the serial input. A later segment takes the tap pin before it
// in write mode, and the tail of the previous segment in shift mode.
// Assumes NSEG >= 2.
module tsr_entry_mux #(
    parameter int unsigned NSEG = 4
) (
    input  logic            din,
    input  logic            wr_en,
    input  logic [NSEG-2:0] tap_in,
    input  logic [NSEG-2:0] prev_tail,
    output logic [NSEG-1:0] entry
);
    assign entry[0] = din;

    for (genvar k = 1; k < NSEG; k++) begin : g_entry
        // Choose between the tap pin and the chained tail for segment k.
        always_comb begin
            entry[k] = wr_en ? tap_in[k-1] : prev_tail[k-1];
        end
    end
endmodule

// File: rtl/tsr_tap_drive.sv
// Module: drive side of the tap pins.
// The taps always present the segment tails. They are enabled only in shift mode, so
// that an outside source can drive them while a write is in progress.
module tsr_tap_drive #(
    parameter int unsigned NSEG = 4
) (
    input  logic            wr_en,
    input  logic [NSEG-1:0] tails,
    output logic [NSEG-1:0] tap_out,
    output logic [NSEG-1:0] tap_oe
);
    // Present tail values and compute the shared drive enable.
    always_comb begin
        tap_out = tails;
        tap_oe  = {NSEG{~wr_en}};
    end
endmodule

// File: rtl/tapshift_reg.sv
// Module: top of the segmented tap-loadable shift register.
// NUM_SEGS segments of SEG_LEN stages are chained. The segment tails are brought out
// as taps. In write mode the taps between segments feed the next segment head, so
// every segment loads at once. Assumes SEG_LEN >= 2 and NUM_SEGS >= 2.
module tapshift_reg
    import tsr_pkg::*;
#(
    parameter int unsigned SEG_LEN  = DEF_SEG_LEN,
    parameter int unsigned NUM_SEGS = DEF_NUM_SEGS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                din,
    input  logic                wr_en,
    input  logic [NUM_SEGS-2:0] tap_in,
    output logic [NUM_SEGS-1:0] tap_out,
    output logic [NUM_SEGS-1:0] tap_oe
);
    localparam int unsigned DEPTH = SEG_LEN * NUM_SEGS;

    logic [NUM_SEGS-1:0] entry;
    logic [NUM_SEGS-1:0] tails;
    logic [DEPTH-1:0]    stage_flat;

    tsr_entry_mux #(.NSEG(NUM_SEGS)) u_mux (
        .din       (din),
        .wr_en     (wr_en),
        .tap_in    (tap_in),
        .prev_tail (tails[NUM_SEGS-2:0]),
        .entry     (entry)
    );

    for (genvar k = 0; k < NUM_SEGS; k++) begin : g_seg
        logic [SEG_LEN-1:0] seg_bits;

        tsr_segment #(.LEN(SEG_LEN)) u_seg (
            .clk   (clk),
            .rst_n (rst_n),
            .entry (entry[k]),
            .bits  (seg_bits)
        );

        // Gather this segment into the flat stage view and take its tail.
        always_comb begin
            stage_flat[seg_head(k, SEG_LEN) +: SEG_LEN] = seg_bits;
            tails[k] = seg_bits[SEG_LEN-1];
        end
    end

    tsr_tap_drive #(.NSEG(NUM_SEGS)) u_drive (
        .wr_en   (wr_en),
        .tails   (tails),
        .tap_out (tap_out),
        .tap_oe  (tap_oe)
    );
endmodule

// File: rtl/tsr_checker.sv
// Module: property checker for tapshift_reg, attached with bind below.
// It sees the ports and the flat stage vector (index 0 = stage 1).
module tsr_checker #(
    parameter int unsigned SEG_LEN  = 16,
    parameter int unsigned NUM_SEGS = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         din,
    input logic                         wr_en,
    input logic [NUM_SEGS-2:0]          tap_in,
    input logic [NUM_SEGS-1:0]          tap_out,
    input logic [NUM_SEGS-1:0]          tap_oe,
    input logic [SEG_LEN*NUM_SEGS-1:0]  stages
);
    localparam int unsigned DEPTH = SEG_LEN * NUM_SEGS;

    // R1 / R8: a clearing edge empties the taps, whatever the mode inputs were.
    p_clear_r1: assert property (@(posedge clk) !rst_n |=> tap_out == '0);

    // R2: serial shift moves every stage by one.
    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (stages[0] == $past(din)) && (stages[DEPTH-1:1] == $past(stages[DEPTH-2:0])));

    // R4: stage 1 keeps taking the serial input in write mode.
    p_head_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> stages[0] == $past(din));

    // R4: the stage-64 tap is never an input; the last stage still chains.
    p_tail_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> stages[DEPTH-1] == $past(stages[DEPTH-2]));

    for (genvar k = 1; k < NUM_SEGS; k++) begin : g_ent
        // R4: each later segment head loads from the tap pin before it.
        p_tap_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en |=> stages[k*SEG_LEN] == $past(tap_in[k-1]));
    end

    // R6: taps are released in write mode and driven in shift mode.
    p_oe_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> tap_oe == '0);
    p_oe_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |-> &tap_oe);
endmodule

bind tapshift_reg tsr_checker #(.SEG_LEN(SEG_LEN), .NUM_SEGS(NUM_SEGS)) u_tsr_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .wr_en   (wr_en),
    .tap_in  (tap_in),
    .tap_out (tap_out),
    .tap_oe  (tap_oe),
    .stages  (stage_flat)
);

// File: tb/test_tapshift_reg.sv
// Bench: random and directed stimulus, compared with a 64-entry reference array.
module test_tapshift_reg;
    localparam int SEG = 16;
    localparam int NS  = 4;
    localparam int D   = SEG * NS;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          din = 1'b0;
    logic          wr_en = 1'b0;
    logic [NS-2:0] tap_in = '0;
    logic [NS-1:0] tap_out;
    logic [NS-1:0] tap_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 0;
    logic [D-1:0] model = '0;

    tapshift_reg #(.SEG_LEN(SEG), .NUM_SEGS(NS)) i_tapshift_reg (
        .clk(clk), .rst_n(rst_n), .din(din), .wr_en(wr_en),
        .tap_in(tap_in), .tap_out(tap_out), .tap_oe(tap_oe)
    );

    always #2 clk = ~clk;

    // Reference next state for one rising edge (index 0 = stage 1).
    function automatic logic [D-1:0] next_model(input logic [D-1:0] m, input logic d,
                                                input logic w, input logic [NS-2:0] t);
        logic [D-1:0] n;
        n = {m[D-2:0], d};
        if (w) begin
            for (int k = 1; k < NS; k++) n[k*SEG] = t[k-1];
        end
        return n;
    endfunction

    // Expected taps: stage 16(k+1) on bit k.
    function automatic logic [NS-1:0] exp_taps(input logic [D-1:0] m);
        logic [NS-1:0] r;
        for (int k = 0; k < NS; k++) r[k] = m[k*SEG + SEG - 1];
        return r;
    endfunction

    task automatic check(input logic [NS-1:0] act, input logic [NS-1:0] exp, input string req);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // One clock: drive at the falling edge, check enables, then taps after the rising edge.
    task automatic step(input logic d, input logic w, input logic [NS-2:0] t,
                        input logic r, input string req);
        @(negedge clk);
        din = d; wr_en = w; tap_in = t; rst_n = r;
        #1 check(tap_oe, w ? '0 : '1, "R6");
        @(posedge clk);
        model = r ? next_model(model, d, w, t) : '0;
        #1 check(tap_out, exp_taps(model), req);
    endtask

    initial begin
        #(4 * 200000);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        if (!done) $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [D-1:0] word;
        void'($urandom(32'd2024));

        // R1 / R8: clear while write mode and all pins are high.
        step(1'b1, 1'b1, '1, 1'b0, "R8");
        step(1'b1, 1'b0, '1, 1'b0, "R1");

        // R2 / R3: walk a single one down the whole register.
        step(1'b1, 1'b0, '0, 1'b1, "R2");
        for (int i = 0; i < D; i++) step(1'b0, 1'b0, '0, 1'b1, "R3");

        // R2 / R7: random serial data with noisy tap pins.
        for (int i = 0; i < 80; i++)
            step(1'($urandom), 1'b0, (NS-1)'($urandom), 1'b1, "R7");
        step(1'b0, 1'b0, '1, 1'b1, "R7");
        step(1'b0, 1'b0, '0, 1'b1, "R7");

        // R4 / R5: 16-clock parallel load, then shift it out through stage 64.
        word = '0;
        for (int j = 0; j < SEG; j++) begin
            logic d;
            logic [NS-2:0] t;
            d = 1'($urandom);
            t = (NS-1)'($urandom);
            word[SEG - 1 - j] = d;
            for (int k = 1; k < NS; k++) word[k*SEG + SEG - 1 - j] = t[k-1];
            step(d, 1'b1, t, 1'b1, "R4");
        end
        for (int i = 0; i < D; i++) begin
            total++;
            if (tap_out[NS-1] !== word[D-1-i]) begin
                bad++;
                $display("FAIL R5 bit %0d actual=%b expected=%b", i, tap_out[NS-1], word[D-1-i]);
            end
            step(1'b0, 1'b0, (NS-1)'($urandom), 1'b1, "R2");
        end

        // Mixed random modes.
        for (int i = 0; i < 400; i++)
            step(1'($urandom), 1'($urandom), (NS-1)'($urandom), 1'b1, "R4");

        // R8: mid-run clear during a write.
        step(1'b1, 1'b1, '1, 1'b0, "R8");
        step(1'b1, 1'b0, '0, 1'b1, "R2");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule